// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Slave

This block lets an external host read and write the 8-bit configuration registers of a device over three wires: a serial clock, an active-low select and one bidirectional data line. Each frame opens with a 16-bit command word. Its top bit selects read (1) or write (0), the next two bits give the transfer length, and the low 13 bits give the starting address. One or more 8-bit data words follow. In a read frame the block takes over the data line once the command word ends and shifts the register contents out.

The serial pins are oversampled by the system clock `clk` and converted into edge events. A frame controller with five named states consumes those events: `S_IDLE`, `S_INSTR` (command word), `S_DATA` (data words), `S_HOLD` (paused at a byte boundary) and `S_DONE` (the counted bytes are complete). The transitions are:
- `S_IDLE`→`S_INSTR` when select falls.
- `S_INSTR`→`S_DATA` on the 16th command bit.
- `S_INSTR`→`S_HOLD` when select rises after exactly 8 command bits, and `S_INSTR`→`S_IDLE` when it rises at any other point.
- `S_DATA`→`S_DONE` after the last counted byte.
- `S_DATA`→`S_HOLD` when select rises at a byte boundary of an unfinished counted transfer, and `S_DATA`→`S_IDLE` when it rises anywhere else.
- `S_HOLD`→`S_INSTR` or `S_DATA` (whichever phase was paused) when select falls again.
- `S_DONE`→`S_IDLE` when select rises.

Registers 0x08 to 0x18 are double-buffered. Host writes land in a pending copy. The copy the device uses, driven on `live_cfg`, changes only when a commit command is written.

Top module: `spi3w_cfg_slave`

## Requirements
- R1: After reset, every register reads 0x00 except 0x18, which reads 0xC0 in both its pending and live copies, and `sdio_oe` is low.
- R2: The command word is always sent most significant bit first. Bit 15 = 1 means read and 0 means write, bits 14:13 give the length code, and bits 12:0 give the start address. Data bits are sampled on rising `sclk`.
- R3: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 bytes. Further clocks in the same frame write nothing.
- R4: Length code 11 streams bytes for as long as `csb` stays low. `csb` rising at a byte boundary ends the stream.
- R5: After each byte the address steps down by one in most-significant-first order and up by one in least-significant-first order.
- R6: `sdio_oe` is high only during the data phase of a read frame while `csb` is low. Each read bit is updated after a falling `sclk` edge, so it is valid at the next rising edge.
- R7: Bit 6 of register 0x00 set to 1 selects least-significant-first order for the data bytes of later frames. The reset order is most significant first.
- R8: In a counted transfer, `csb` rising at a byte boundary (after 8 command bits, or between data bytes) pauses the frame. When `csb` falls again, the frame resumes where it stopped.
- R9: `csb` rising part-way through a byte aborts the frame, and the partial byte is not written.
- R10: Writes to 0x08..0x18 show on `live_cfg` (byte k is register 0x08+k) only after the byte 0x01 is written to address 0xFF. At that point all of those registers are copied at once.
- R11: Address 0xFF always reads 0x00, and a write there with bit 0 clear has no effect.
- R12: Addresses at or above NREG (32), apart from 0xFF, ignore writes and read 0x00. They do not alias onto low registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Data line output enable |
| live_cfg | output | 136 | Live copies of registers 0x08..0x18, byte k = 0x08+k |

## Verification
The bench builds the block with its defaults: 32 registers, shadow window 0x08..0x18, and a two-stage pin synchronizer. With 32 registers, address 0x40 shares its low bits with the order-select register 0x00, so any aliasing of out-of-range writes would change the bit order and show up. The serial clock runs at 12 system clocks per bit, which leaves enough settling time to sample read bits at the port. A 17-byte live window lets the commit path be checked both partly and fully.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_INSTR,
        S_DATA,
        S_HOLD,
        S_DONE
    } frame_state_t;

    localparam int CMD_BITS = 16;
    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/spi3w_pin_sync.sv
module spi3w_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csb,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csb_rise,
    output logic csb_fall,
    output logic csb_lo,
    output logic sdi_s
);
    logic [STAGES-1:0] sclk_p, csb_p, sdi_p;
    logic sclk_q, csb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            csb_p  <= '1;
            sdi_p  <= '0;
            sclk_q <= 1'b0;
            csb_q  <= 1'b1;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            csb_p  <= {csb_p[STAGES-2:0], csb};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi};
            sclk_q <= sclk_p[STAGES-1];
            csb_q  <= csb_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_q;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_q;
    assign csb_rise  = csb_p[STAGES-1] & ~csb_q;
    assign csb_fall  = ~csb_p[STAGES-1] & csb_q;
    assign csb_lo    = ~csb_p[STAGES-1];
    assign sdi_s     = sdi_p[STAGES-1];
endmodule

// File: rtl/spi3w_frame_fsm.sv
module spi3w_frame_fsm
    import spi3w_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              csb_rise,
    input  logic              csb_fall,
    input  logic              csb_lo,
    input  logic              sdi,
    input  logic              lsb_cfg,
    input  logic [7:0]        rd_data,
    output frame_state_t      st,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CW = $clog2(CMD_BITS + 1);
    localparam int BW = $clog2(BYTE_BITS);

    frame_state_t nxt;
    logic [CMD_BITS-2:0] instr_sr;
    logic [CW-1:0]       icnt;
    logic [BW-1:0]       bcnt;
    logic [7:0]          rx_sr, tx_byte, nb_rx, cur_byte;
    logic [ADDR_W-1:0]   addr;
    logic [1:0]          left;
    logic                is_rd, stream, lsb, in_data;
    logic [BW-1:0]       bit_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (csb_fall) nxt = S_INSTR;
            S_INSTR: begin
                if (csb_rise)
                    nxt = (icnt == CW'(BYTE_BITS)) ? S_HOLD : S_IDLE;
                else if (sclk_rise && icnt == CW'(CMD_BITS - 1))
                    nxt = S_DATA;
            end
            S_DATA: begin
                if (csb_rise)
                    nxt = (bcnt == '0 && !stream) ? S_HOLD : S_IDLE;
                else if (sclk_rise && bcnt == BW'(BYTE_BITS - 1) && !stream && left == 2'd0)
                    nxt = S_DONE;
            end
            S_HOLD:  if (csb_fall) nxt = in_data ? S_DATA : S_INSTR;
            S_DONE:  if (csb_rise) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign nb_rx    = lsb ? {sdi, rx_sr[7:1]} : {rx_sr[6:0], sdi};
    assign cur_byte = (bcnt == '0) ? rd_data : tx_byte;
    assign bit_idx  = lsb ? bcnt : (BW'(BYTE_BITS - 1) - bcnt);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_sr <= '0; icnt <= '0; bcnt <= '0;
            rx_sr <= '0; tx_byte <= '0; addr <= '0; left <= '0;
            is_rd <= 1'b0; stream <= 1'b0; lsb <= 1'b0; in_data <= 1'b0;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; sdo <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (st == S_IDLE) begin
                icnt <= '0;
                bcnt <= '0;
                in_data <= 1'b0;
            end
            if (st == S_INSTR && sclk_rise) begin
                instr_sr <= {instr_sr[CMD_BITS-3:0], sdi};
                icnt     <= icnt + 1'b1;
                if (icnt == CW'(CMD_BITS - 1)) begin
                    is_rd   <= instr_sr[14];
                    left    <= instr_sr[13:12];
                    stream  <= &instr_sr[13:12];
                    addr    <= {instr_sr[11:0], sdi};
                    lsb     <= lsb_cfg;
                    bcnt    <= '0;
                    in_data <= 1'b1;
                end
            end
            if (st == S_DATA && sclk_rise) begin
                rx_sr <= nb_rx;
                bcnt  <= bcnt + 1'b1;
                if (bcnt == BW'(BYTE_BITS - 1)) begin
                    if (!is_rd) begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr;
                        wr_data <= nb_rx;
                    end
                    addr <= lsb ? addr + 1'b1 : addr - 1'b1;
                    if (!stream && left != 2'd0) left <= left - 2'd1;
                end
            end
            if (st == S_DATA && sclk_fall) begin
                sdo <= cur_byte[bit_idx];
                if (bcnt == '0) tx_byte <= rd_data;
            end
        end
    end

    assign rd_addr = addr;
    assign sdo_oe  = (st == S_DATA) && is_rd && csb_lo;
endmodule

// File: rtl/spi3w_reg_bank.sv
module spi3w_reg_bank #(
    parameter int         ADDR_W   = 13,
    parameter int         NREG     = 32,
    parameter int         SH_LO    = 8,
    parameter int         SH_HI    = 24,
    parameter int         RST_ADDR = 24,
    parameter logic [7:0] RST_VAL  = 8'hC0,
    parameter int         LSB_BIT  = 6,
    localparam int        NSH      = SH_HI - SH_LO + 1,
    localparam int        IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              lsb_cfg,
    output logic [NSH*8-1:0]  live_cfg
);
    logic [7:0] regs_q [NREG];
    logic [7:0] live_q [NSH];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [7:0] RV = (i == RST_ADDR) ? RST_VAL : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[i] <= RV;
            else if (wr_en && wr_addr == ADDR_W'(i)) regs_q[i] <= wr_data;
        end
    end

    for (genvar k = 0; k < NSH; k++) begin : g_live
        localparam logic [7:0] LV = ((SH_LO + k) == RST_ADDR) ? RST_VAL : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) live_q[k] <= LV;
            else if (commit) live_q[k] <= regs_q[SH_LO + k];
        end
        assign live_cfg[8*k +: 8] = live_q[k];
    end

    assign rd_data = (rd_addr < ADDR_W'(NREG)) ? regs_q[rd_addr[IDX_W-1:0]] : 8'h00;
    assign lsb_cfg = regs_q[0][LSB_BIT];
endmodule

// File: rtl/spi3w_cfg_slave.sv
module spi3w_cfg_slave
    import spi3w_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int NREG        = 32,
    parameter int SH_LO       = 8,
    parameter int SH_HI       = 24,
    parameter int COMMIT_ADDR = 255,
    parameter int SYNC_STAGES = 2,
    localparam int LIVE_W     = (SH_HI - SH_LO + 1) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              csb,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic [LIVE_W-1:0] live_cfg
);
    logic sclk_rise, sclk_fall, csb_rise, csb_fall, csb_lo, sdi_s;
    logic lsb_cfg, wr_en, commit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    frame_state_t st;

    spi3w_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdi(sdio_i),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .csb_rise(csb_rise), .csb_fall(csb_fall), .csb_lo(csb_lo), .sdi_s(sdi_s)
    );

    spi3w_frame_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .csb_rise(csb_rise), .csb_fall(csb_fall), .csb_lo(csb_lo), .sdi(sdi_s),
        .lsb_cfg(lsb_cfg), .rd_data(rd_data), .st(st), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdio_o), .sdo_oe(sdio_oe)
    );

    assign commit = wr_en && (wr_addr == ADDR_W'(COMMIT_ADDR)) && wr_data[0];

    spi3w_reg_bank #(
        .ADDR_W(ADDR_W), .NREG(NREG), .SH_LO(SH_LO), .SH_HI(SH_HI),
        .RST_ADDR(SH_HI), .RST_VAL(8'hC0), .LSB_BIT(6)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .rd_addr(rd_addr),
        .rd_data(rd_data), .lsb_cfg(lsb_cfg), .live_cfg(live_cfg)
    );
endmodule

// File: rtl/spi3w_cfg_checks.sv
module spi3w_cfg_checks
    import spi3w_pkg::*;
#(
    parameter int LIVE_W = 136
) (
    input logic              clk,
    input logic              rst_n,
    input frame_state_t      st,
    input logic              wr_en,
    input logic              commit,
    input logic              sdio_oe,
    input logic [LIVE_W-1:0] live_cfg
);
    // R10: live copies move only in the cycle after a commit write
    a_r10_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_cfg));

    // R6: data line is driven only in the data phase
    a_r6_oe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> st == S_DATA);

    // R6: a read frame never issues a register write
    a_r6_oe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !wr_en);

    // R3: at most one byte write per byte period
    a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2: writes come only out of the data phase
    a_r2_write_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(st) == S_DATA);
endmodule

bind spi3w_cfg_slave spi3w_cfg_checks #(.LIVE_W(LIVE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .wr_en(wr_en), .commit(commit),
    .sdio_oe(sdio_oe), .live_cfg(live_cfg)
);

// File: tb/tb_spi3w_cfg_slave.sv
module tb_spi3w_cfg_slave;
    localparam int H = 6;
    localparam int NREG = 32;
    localparam int NSH = 17;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, csb = 1'b1, sdio_i = 1'b0;
    logic sdio_o, sdio_oe;
    logic [NSH*8-1:0] live_cfg;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] mem [NREG];
    logic [7:0] live_m [NSH];
    logic [7:0] txq [16];
    logic [7:0] rxq [16];
    int csb_hi_cnt = 0;

    spi3w_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .live_cfg(live_cfg)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // R6 per-clock: output never enabled while select has been high a while
    always @(negedge clk) begin
        csb_hi_cnt = csb ? csb_hi_cnt + 1 : 0;
        if (rst_n && csb_hi_cnt >= 3 && sdio_oe) begin
            errors++;
            $display("FAIL R6 oe high with csb high act=1 exp=0");
        end
    end

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lsb, output logic [7:0] r);
        r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            int idx = lsb ? i : 7 - i;
            sdio_i = b[idx];
            hw();
            r[idx] = sdio_o;
            sclk = 1'b1;
            hw();
            sclk = 1'b0;
        end
    endtask

    function automatic logic [7:0] m_read(input int a);
        return (a < NREG) ? mem[a] : 8'h00;
    endfunction

    task automatic m_write(input int a, input logic [7:0] d);
        if (a == 255) begin
            if (d[0]) for (int k = 0; k < NSH; k++) live_m[k] = mem[8 + k];
        end else if (a < NREG) mem[a] = d;
    endtask

    function automatic logic [135:0] live_vec();
        logic [135:0] v;
        for (int k = 0; k < NSH; k++) v[8*k +: 8] = live_m[k];
        return v;
    endfunction

    task automatic pause();
        hw(); csb = 1'b1; repeat (3) hw(); csb = 1'b0; hw();
    endtask

    // pause_at: -2 none, -1 after first command byte, k after data byte k
    task automatic do_frame(input bit rd, input logic [1:0] w, input logic [12:0] a,
                            input int nb, input int pause_at, input string req);
        logic [15:0] cmd;
        logic [7:0] junk;
        bit lsb_m;
        int len;
        logic [12:0] cur;
        lsb_m = mem[0][6];
        cmd = {rd, w, a};
        csb = 1'b0; hw();
        send_byte(cmd[15:8], 1'b0, junk);
        if (pause_at == -1) pause();
        send_byte(cmd[7:0], 1'b0, junk);
        hw();
        check(sdio_oe == rd, {req, " R6 oe in data phase"}, 136'(sdio_oe), 136'(rd));
        for (int k = 0; k < nb; k++) begin
            send_byte(txq[k], lsb_m, rxq[k]);
            if (pause_at == k) pause();
        end
        hw(); csb = 1'b1; hw(); hw();
        len = (w == 2'b11) ? nb : ((nb < int'(w) + 1) ? nb : int'(w) + 1);
        cur = a;
        for (int k = 0; k < len; k++) begin
            if (rd) check(rxq[k] == m_read(int'(cur)), req, 136'(rxq[k]), 136'(m_read(int'(cur))));
            else m_write(int'(cur), txq[k]);
            cur = lsb_m ? cur + 13'd1 : cur - 13'd1;
        end
    endtask

    task automatic rd_one(input logic [12:0] a, input string req);
        do_frame(1'b1, 2'b00, a, 1, -2, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mem[i] = (i == 24) ? 8'hC0 : 8'h00;
        for (int k = 0; k < NSH; k++) live_m[k] = (k == 16) ? 8'hC0 : 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check(sdio_oe == 1'b0, "R1 oe after reset", 136'(sdio_oe), 136'(0));
        check(live_cfg == live_vec(), "R1 live after reset", live_cfg, live_vec());
        rd_one(13'h18, "R1 read 0x18");
        rd_one(13'h05, "R1 read 0x05");

        // R2 single write and read back
        txq[0] = 8'h3C; do_frame(1'b0, 2'b00, 13'h05, 1, -2, "R2 write");
        rd_one(13'h05, "R2 read back");

        // R3/R5 three-byte descending write, read back
        txq[0] = 8'h11; txq[1] = 8'h22; txq[2] = 8'h33;
        do_frame(1'b0, 2'b10, 13'h07, 3, -2, "R3 write 3");
        do_frame(1'b1, 2'b10, 13'h07, 3, -2, "R5 read 3 descending");

        // R3 extra bytes after counted length are ignored
        txq[0] = 8'h5A; txq[1] = 8'hEE;
        do_frame(1'b0, 2'b00, 13'h02, 2, -2, "R3 extra");
        rd_one(13'h01, "R3 byte past length not written");
        rd_one(13'h02, "R3 counted byte written");

        // R10/R11 shadow and commit
        txq[0] = 8'h9D; do_frame(1'b0, 2'b00, 13'h08, 1, -2, "R10 shadow write");
        txq[0] = 8'h4E; do_frame(1'b0, 2'b00, 13'h18, 1, -2, "R10 shadow write");
        check(live_cfg == live_vec(), "R10 live unchanged before commit", live_cfg, live_vec());
        rd_one(13'h08, "R10 pending readable");
        txq[0] = 8'h02; do_frame(1'b0, 2'b00, 13'h0FF, 1, -2, "R11 no-op");
        check(live_cfg == live_vec(), "R11 bit0 clear ignored", live_cfg, live_vec());
        txq[0] = 8'h01; do_frame(1'b0, 2'b00, 13'h0FF, 1, -2, "R10 commit");
        check(live_cfg == live_vec(), "R10 live after commit", live_cfg, live_vec());
        rd_one(13'h0FF, "R11 commit reads zero");

        // R4 streaming
        for (int k = 0; k < 5; k++) txq[k] = 8'hA0 + 8'(k);
        do_frame(1'b0, 2'b11, 13'h1F, 5, -2, "R4 stream write");
        do_frame(1'b1, 2'b11, 13'h1F, 5, -2, "R4 stream read");

        // R8 pauses
        txq[0] = 8'h61; txq[1] = 8'h62; txq[2] = 8'h63;
        do_frame(1'b0, 2'b10, 13'h12, 3, -1, "R8 pause in command");
        txq[0] = 8'h71; txq[1] = 8'h72; txq[2] = 8'h73;
        do_frame(1'b0, 2'b10, 13'h0E, 3, 0, "R8 pause in data");
        do_frame(1'b1, 2'b10, 13'h12, 3, 1, "R8 read with pause");
        do_frame(1'b1, 2'b10, 13'h0E, 3, -2, "R8 read back");

        // R9 abort mid-byte
        begin
            logic [7:0] junk;
            csb = 1'b0; hw();
            send_byte(8'h00, 1'b0, junk);
            send_byte(8'h03, 1'b0, junk);
            for (int i = 0; i < 4; i++) begin
                sdio_i = 1'b1; hw(); sclk = 1'b1; hw(); sclk = 1'b0;
            end
            hw(); csb = 1'b1; hw(); hw();
        end
        rd_one(13'h03, "R9 aborted byte not written");

        // R12 out of range, no alias onto 0x00
        txq[0] = 8'h77; do_frame(1'b0, 2'b00, 13'h040, 1, -2, "R12 write");
        rd_one(13'h040, "R12 reads zero");
        rd_one(13'h000, "R12 no alias");

        // R7/R5 least-significant-first mode
        txq[0] = 8'h40; do_frame(1'b0, 2'b00, 13'h000, 1, -2, "R7 set order");
        txq[0] = 8'hA5; txq[1] = 8'h3C;
        do_frame(1'b0, 2'b01, 13'h0A, 2, -2, "R7 lsb write");
        do_frame(1'b1, 2'b01, 13'h0A, 2, -2, "R5 lsb ascending read");
        txq[0] = 8'h01; do_frame(1'b0, 2'b00, 13'h0FF, 1, -2, "R10 commit 2");
        check(live_cfg == live_vec(), "R10 live after second commit", live_cfg, live_vec());

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule